// File: doc/BRIEF.md
# Three-Wire Command/Data Serial Receiver

This block receives a write-only serial stream from a host controller over three wires: an active-low chip enable, a serial clock and a serial data line. The stream is cut into 9-bit frames. The leading bit of each frame is a kind flag that sends the following byte either to a command output or to a display-RAM write port. Frames follow one another with no gap for as long as chip enable stays low.

All three serial inputs pass through a two-flop synchroniser into the faster system clock domain. Serial clock rises are found there by edge detection, so no flop is clocked by the serial clock. RAM writes carry a 9-bit address from an internal counter. The counter covers 0 to 503 and steps once after every data byte. A neighbouring command decoder can reload it through a load port. The system reset aborts any frame in progress and clears the counter.

The framing state machine has three states:
- `ST_HOLD`: chip enable is high, or the block has just left reset.
- `ST_FLAG`: waiting for the kind flag.
- `ST_BITS`: collecting the eight byte bits.

Its transitions are:
- HOLD→FLAG: synchronised chip enable goes low.
- FLAG→BITS: a serial clock rise captures the flag.
- BITS→FLAG: the eighth byte bit arrives, and the byte is emitted.
- FLAG/BITS→HOLD: chip enable goes high.

Top module: `tw_cmd_data_rx`

## Requirements
- R1: While chip enable (`sce_n`) is high, serial clock edges have no effect: no strobe is produced and the RAM address does not change.
- R2: The first bit sampled in a frame is the kind flag. Flag 0 gives a one-cycle `cmd_vld` with the byte on `cmd_byte`. Flag 1 gives a one-cycle `ram_we` with the byte on `ram_wdata`.
- R3: `sdin` is sampled on each rising edge of `sclk`, and the eight byte bits arrive most significant bit first.
- R4: While `sce_n` stays low, the rise after a frame's last bit samples the flag of a new frame. Command and data frames may be mixed in any order.
- R5: During a write, `ram_addr` shows the counter value. The counter then increments by one.
- R6: The address counter holds values 0..503 and wraps from 503 to 0 on a write.
- R7: A one-cycle `ld_addr_en` loads `ld_addr_val` into the counter. A value above 503 loads 0. A load takes priority over an increment in the same cycle.
- R8: A low `rst_n` has the following effects:
  - it aborts a partial frame without any strobe;
  - it forces strobes low and the address to 0;
  - if `sce_n` is low when reset is released, the next `sclk` rise is taken as a flag.
- R9: Raising `sce_n` in the middle of a frame discards the partial frame. The next frame after `sce_n` falls starts with a flag.
- R10: `cmd_vld` and `ram_we` are never high together and each is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Active-low hardware reset, asynchronous assert |
| sce_n | input | 1 | Serial chip enable, active low |
| sclk | input | 1 | Serial clock from host |
| sdin | input | 1 | Serial data from host |
| ld_addr_en | input | 1 | Load strobe for the address counter |
| ld_addr_val | input | 9 | Address to load |
| cmd_vld | output | 1 | Command byte strobe |
| cmd_byte | output | 8 | Received command byte |
| ram_we | output | 1 | Display RAM write strobe |
| ram_addr | output | 9 | Display RAM write address (counter value) |
| ram_wdata | output | 8 | Display RAM write data |

## Verification
A single command frame with an alternating pattern (0xA5) tells MSB-first order apart from LSB-first. Runs of mixed command and data frames in one chip-enable window show that back-to-back framing keeps its bit alignment and routes each byte by its own flag. Serial clock bursts with chip enable high, a chip-enable rise after five bits, and a reset after four bits each show that a partial frame leaves no strobe. After each of these, the next frame is decoded cleanly. Counter loads at 502 and at an out-of-range value, followed by data frames, show the wrap point and the clamp.

// File: rtl/tw_rx_pkg.sv
package tw_rx_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_FLAG = 2'd1,
        ST_BITS = 2'd2
    } rx_state_e;

    typedef enum logic {
        KIND_CMD = 1'b0,
        KIND_RAM = 1'b1
    } frame_kind_e;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/tw_frame_fsm.sv
module tw_frame_fsm
    import tw_rx_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n_s,
    input  logic              sclk_s,
    input  logic              sdin_s,
    output logic              byte_done,
    output frame_kind_e       byte_kind,
    output logic [BYTE_W-1:0] byte_val
);

    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    rx_state_e          state, state_d;
    logic               sclk_q;
    logic               rise;
    logic [CNT_W-1:0]   bit_cnt;
    logic [BYTE_W-1:0]  shreg;
    frame_kind_e        kind_q;

    assign rise = sclk_s & ~sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_HOLD: if (!ce_n_s) state_d = ST_FLAG;
            ST_FLAG: begin
                if (ce_n_s)    state_d = ST_HOLD;
                else if (rise) state_d = ST_BITS;
            end
            ST_BITS: begin
                if (ce_n_s)                          state_d = ST_HOLD;
                else if (rise && bit_cnt == LAST_BIT) state_d = ST_FLAG;
            end
            default: state_d = ST_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            kind_q    <= KIND_CMD;
            byte_done <= 1'b0;
            byte_kind <= KIND_CMD;
            byte_val  <= '0;
        end else begin
            byte_done <= 1'b0;
            if (!ce_n_s && rise) begin
                unique case (state)
                    ST_FLAG: begin
                        kind_q  <= frame_kind_e'(sdin_s);
                        bit_cnt <= '0;
                    end
                    ST_BITS: begin
                        shreg   <= {shreg[BYTE_W-2:0], sdin_s};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == LAST_BIT) begin
                            byte_done <= 1'b1;
                            byte_kind <= kind_q;
                            byte_val  <= {shreg[BYTE_W-2:0], sdin_s};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1, R9: chip enable high forces the hold state
    p_hold_on_ce_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n_s |=> state == ST_HOLD);

    // R3: a byte completes only out of the bit-collecting state on a rise
    p_done_from_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> ($past(state) == ST_BITS && $past(rise)));

    // R10: completion is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);

endmodule

// File: rtl/tw_addr_ctr.sv
module tw_addr_ctr #(
    parameter int ADDR_W   = 9,
    parameter int ADDR_MAX = 503
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_val,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] TOP = ADDR_W'(ADDR_MAX);

    logic [ADDR_W-1:0] ld_clamped;
    assign ld_clamped = (ld_val > TOP) ? '0 : ld_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           addr <= '0;
        else if (ld)          addr <= ld_clamped;
        else if (inc)         addr <= (addr == TOP) ? '0 : addr + 1'b1;
    end

    p_addr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        addr <= TOP);

    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inc) && !$past(ld) && $past(addr) != TOP) |-> addr == $past(addr) + 1'b1);

    p_addr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inc) && !$past(ld) && $past(addr) == TOP) |-> addr == '0);

    p_load_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ld) && $past(ld_val) <= TOP) |-> addr == $past(ld_val));

endmodule

// File: rtl/tw_cmd_data_rx.sv
module tw_cmd_data_rx
    import tw_rx_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int ADDR_W      = 9,
    parameter int ADDR_MAX    = 503,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sce_n,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              ld_addr_en,
    input  logic [ADDR_W-1:0] ld_addr_val,
    output logic              cmd_vld,
    output logic [BYTE_W-1:0] cmd_byte,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [BYTE_W-1:0] ram_wdata
);

    logic [2:0]        sync_q;
    logic              done;
    frame_kind_e       kind;
    logic [BYTE_W-1:0] val;

    tw_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sce_n, sclk, sdin}),
        .q     (sync_q)
    );

    tw_frame_fsm #(
        .BYTE_W (BYTE_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n_s    (sync_q[2]),
        .sclk_s    (sync_q[1]),
        .sdin_s    (sync_q[0]),
        .byte_done (done),
        .byte_kind (kind),
        .byte_val  (val)
    );

    assign cmd_vld   = done && (kind == KIND_CMD);
    assign ram_we    = done && (kind == KIND_RAM);
    assign cmd_byte  = val;
    assign ram_wdata = val;

    tw_addr_ctr #(
        .ADDR_W   (ADDR_W),
        .ADDR_MAX (ADDR_MAX)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (ram_we),
        .ld     (ld_addr_en),
        .ld_val (ld_addr_val),
        .addr   (ram_addr)
    );

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_vld && ram_we));

    p_ram_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);

endmodule

// File: tb/sim_tw_cmd_data_rx.sv
module sim_tw_cmd_data_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sce_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdin = 1'b0;
    logic       ld_addr_en = 1'b0;
    logic [8:0] ld_addr_val = '0;
    logic       cmd_vld, ram_we;
    logic [7:0] cmd_byte, ram_wdata;
    logic [8:0] ram_addr;

    always #5 clk = ~clk;

    tw_cmd_data_rx u0 (
        .clk(clk), .rst_n(rst_n), .sce_n(sce_n), .sclk(sclk), .sdin(sdin),
        .ld_addr_en(ld_addr_en), .ld_addr_val(ld_addr_val),
        .cmd_vld(cmd_vld), .cmd_byte(cmd_byte), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int strobes = 0;
    int exp_addr = 0;
    logic [7:0]  cmdq[$];
    logic [16:0] ramq[$];
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model compared on every clock
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (cmd_vld || ram_we) strobes++;
            if (cmd_vld && ram_we) chk(0, "R10 both strobes", 1, 0);
            if (cmd_vld) begin
                if (cmdq.size() == 0) chk(0, "R2 unexpected command", int'(cmd_byte), -1);
                else begin
                    logic [7:0] e;
                    e = cmdq.pop_front();
                    chk(cmd_byte == e, "R2/R3 command byte", int'(cmd_byte), int'(e));
                end
            end
            if (ram_we) begin
                if (ramq.size() == 0) chk(0, "R2 unexpected ram write", int'(ram_wdata), -1);
                else begin
                    logic [16:0] e;
                    e = ramq.pop_front();
                    chk(ram_wdata == e[7:0], "R2/R3 ram data", int'(ram_wdata), int'(e[7:0]));
                    chk(ram_addr == e[16:8], "R5 ram address", int'(ram_addr), int'(e[16:8]));
                end
            end
        end
        if (cyc > 150000 && !done) begin
            done = 1;
            chk(0, "watchdog expired", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        sdin = b; wclk(4);
        sclk = 1'b1; wclk(4);
        sclk = 1'b0;
    endtask

    task automatic frame(input bit f, input logic [7:0] b);
        if (f) begin
            ramq.push_back({9'(exp_addr), b});
            exp_addr = (exp_addr == 503) ? 0 : exp_addr + 1;
        end else cmdq.push_back(b);
        send_bit(f);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic ce_low;  sce_n = 1'b0; wclk(4); endtask
    task automatic ce_high; wclk(4); sce_n = 1'b1; wclk(4); endtask

    task automatic drain(input string tag);
        wclk(20);
        chk(cmdq.size() == 0 && ramq.size() == 0, tag, cmdq.size() + ramq.size(), 0);
    endtask

    task automatic load(input int v);
        ld_addr_val = 9'(v); ld_addr_en = 1'b1;
        wclk(1);
        ld_addr_en = 1'b0;
        exp_addr = (v > 503) ? 0 : v;
        wclk(2);
        chk(ram_addr == 9'(exp_addr), "R7 loaded address", int'(ram_addr), exp_addr);
    endtask

    initial begin
        int s0;
        wclk(3);
        chk(!cmd_vld && !ram_we, "R8 strobes low in reset", int'(cmd_vld | ram_we), 0);
        chk(ram_addr == 0, "R8 address zero in reset", int'(ram_addr), 0);
        rst_n = 1'b1; wclk(5);

        // R2 R3: single command, MSB-first pattern
        ce_low; frame(0, 8'hA5); ce_high; drain("R2 single command");

        // R4 R5: mixed back-to-back frames in one window
        ce_low;
        frame(1, 8'h3C); frame(0, 8'h01); frame(1, 8'hC3); frame(1, 8'h80); frame(0, 8'hFE);
        ce_high; drain("R4 back-to-back frames");

        // R1: clocks with chip enable high
        s0 = strobes;
        for (int i = 0; i < 12; i++) send_bit(i[0]);
        drain("R1 queue");
        chk(strobes == s0, "R1 no strobe while disabled", strobes, s0);
        chk(ram_addr == 9'(exp_addr), "R1 address unchanged", int'(ram_addr), exp_addr);

        // R9: abort by chip enable mid-frame
        ce_low;
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        ce_high;
        ce_low; frame(0, 8'h5A); ce_high; drain("R9 resync after abort");

        // R6 R7: wrap and clamp
        load(502);
        ce_low; frame(1, 8'h11); frame(1, 8'h22); frame(1, 8'h33); ce_high;
        drain("R6 wrap sequence");
        chk(ram_addr == 1, "R6 address after wrap", int'(ram_addr), 1);
        load(510);
        ce_low; frame(1, 8'h44); ce_high; drain("R7 clamped load");

        // R8: reset mid-frame with chip enable low
        load(100);
        ce_low;
        frame(1, 8'h99);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        s0 = strobes;
        rst_n = 1'b0; wclk(3);
        chk(ram_addr == 0, "R8 address cleared", int'(ram_addr), 0);
        rst_n = 1'b1; exp_addr = 0; wclk(10);
        chk(strobes == s0, "R8 no strobe from partial frame", strobes, s0);
        frame(1, 8'h77); frame(0, 8'h0F);
        ce_high; drain("R8 ready after reset");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule